// File: doc/BRIEF.md
# Interrupt status and mask aggregator

This block gathers one-cycle event pulses from a PCIe controller's client logic and from its core error logic, holds each one in a sticky status bit, and turns the pending bits into three interrupt lines. The lines are a subsystem line, a client line and a legacy INTx line. Software reaches the block through a small 32-bit register bus with a write strobe, a word address and a read port that answers without wait states. Status bits are cleared by writing 1 to them.

The client mask takes per-bit write enables from the upper half of the written word, so one mask bit can be changed without reading the register first. Client status bit 4 is not a latch. It shows whether any core error that is not masked is still pending, which links the two status levels together. A small dispatcher reports the lowest pending legacy line. The lines INTA to INTD are numbered 0 to 3.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, client status and core status read 0, the client mask reads 0x0000FFFF, the core mask reads 0xFFFFFFFF, and irq_sub, irq_cli, irq_intx and intx_vld are all low.
- R2: A pulse on cli_evt[i], for any i other than 4, sets client status bit i at the next clock edge. The bit stays set until software clears it. Client status bit positions: 0 power-state change, 1 hot-plug, 2 PHY, 3 micro-DMA, 4 local summary, 5..8 INTA..INTD, 9 correctable error, 10 non-fatal error, 11 fatal error, 12 DPA, 13 hot reset, 14 message, 15 legacy done.
- R3: Writing a word to client status (word address 0) or to core status (word address 2) clears each bit that is 1 in the written word. Bits written as 0 keep their value.
- R4: When an event pulse and a clear of the same status bit fall in the same cycle, the event wins and the bit stays set.
- R5: A write to the client mask (word address 1) changes mask bit x only when bit x+16 of the written word is 1. The new value of bit x is then bit x of the written word. The upper 16 bits read back as 0.
- R6: Core status (word address 2) implements only bits 0..11, 18 and 19 (set 0x000C0FFF). Events on the other bits are ignored, and those bits read 0.
- R7: Client status bit 4 reads 1 exactly while some core status bit is set whose core mask bit (word address 3, plain 32-bit write) is 0. Writing 1 to client status bit 4, or a pulse on cli_evt[4], has no effect on it.
- R8: A mask bit of 1 disables its source. irq_sub is the OR of unmasked client bits 0..4. irq_cli is the OR of unmasked bits 9..15. irq_intx is the OR of unmasked bits 5..8.
- R9: intx_vld is 1 when any of client status bits 8..5 is set, whatever the mask. intx_idx then gives the index (0..3) of the lowest set bit in that field. Word address 4 reads intx_vld at bit 8 and intx_idx at bits 1:0.
- R10: Word addresses 5 and above read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| cli_evt | input | 16 | Client event pulses, one per status bit |
| core_evt | input | 32 | Core error event pulses |
| irq_sub | output | 1 | Subsystem interrupt |
| irq_cli | output | 1 | Client interrupt |
| irq_intx | output | 1 | Legacy INTx interrupt |
| intx_idx | output | 2 | Lowest pending INTx line |
| intx_vld | output | 1 | Some INTx status bit is pending |

## Verification
The bench checks an event that arrives in the same cycle as its own clear. A design that gave priority to the clear would lose that event, and status would read 0 where 1 is expected. It writes mask words whose enable half and value half disagree. A design that ignored the enables would read back a changed bit that should have stayed put. It drives client bit 4 from the event input and through a clear write, and checks that only the core-side path moves it. It also raises two INTx lines together and clears the lower one. A dispatcher that picked the highest line, or that never updated its answer, would return the wrong index.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int REG_W     = 32;
    localparam int CLI_W     = 16;
    localparam int INTX_N    = 4;

    // client status bit groups
    localparam int LOCAL_BIT = 4;
    localparam int SUB_LO    = 0;
    localparam int SUB_HI    = 4;
    localparam int INTX_LO   = 5;
    localparam int INTX_HI   = 8;
    localparam int CLI_LO    = 9;
    localparam int CLI_HI    = 15;

    // word addresses
    localparam int WA_CLI_STAT  = 0;
    localparam int WA_CLI_MASK  = 1;
    localparam int WA_CORE_STAT = 2;
    localparam int WA_CORE_MASK = 3;
    localparam int WA_INTX      = 4;

    localparam logic [CLI_W-1:0] LOCAL_ONEHOT = CLI_W'(1) << LOCAL_BIT;

endpackage

// File: rtl/irq_w1c_bank.sv
module irq_w1c_bank #(
    parameter int          W    = 16,
    parameter logic [W-1:0] IMPL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] stat_o
);

    logic [W-1:0] stat_q;
    logic [W-1:0] stat_d;

    // a set in the same cycle as a clear keeps the bit
    always_comb begin
        stat_d = ((stat_q & ~clr_i) | set_i) & IMPL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= stat_d;
        end
    end

    assign stat_o = stat_q;

endmodule

// File: rtl/irq_hiword_mask.sv
module irq_hiword_mask #(
    parameter int           W   = 16,
    parameter logic [W-1:0] RST = '1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [2*W-1:0] wdata,
    output logic [W-1:0]   mask_o
);

    logic [W-1:0] mask_q;
    logic [W-1:0] wen;
    logic [W-1:0] mask_d;

    always_comb begin
        wen    = wdata[2*W-1:W];
        mask_d = (mask_q & ~wen) | (wdata[W-1:0] & wen);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= RST;
        end else if (we) begin
            mask_q <= mask_d;
        end
    end

    assign mask_o = mask_q;

endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic [IW-1:0] idx,
    output logic          vld
);

    always_comb begin
        idx = '0;
        vld = |req;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IW'(i);
            end
        end
    end

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int                 ADDR_W        = 3,
    parameter logic [REG_W-1:0]   CORE_IMPL     = 32'h000C_0FFF,
    parameter logic [CLI_W-1:0]   CLI_MASK_RST  = '1,
    parameter logic [REG_W-1:0]   CORE_MASK_RST = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [15:0]       cli_evt,
    input  logic [31:0]       core_evt,
    output logic              irq_sub,
    output logic              irq_cli,
    output logic              irq_intx,
    output logic [1:0]        intx_idx,
    output logic              intx_vld
);

    localparam logic [CLI_W-1:0] CLI_IMPL = ~LOCAL_ONEHOT;

    // address decode
    logic sel_cli_stat, sel_cli_mask, sel_core_stat, sel_core_mask, sel_intx;

    always_comb begin
        sel_cli_stat  = (bus_addr == ADDR_W'(WA_CLI_STAT));
        sel_cli_mask  = (bus_addr == ADDR_W'(WA_CLI_MASK));
        sel_core_stat = (bus_addr == ADDR_W'(WA_CORE_STAT));
        sel_core_mask = (bus_addr == ADDR_W'(WA_CORE_MASK));
        sel_intx      = (bus_addr == ADDR_W'(WA_INTX));
    end

    // core status and mask
    logic [REG_W-1:0] core_stat;
    logic [REG_W-1:0] core_clr;
    logic [REG_W-1:0] core_mask;

    assign core_clr = (bus_we && sel_core_stat) ? bus_wdata : '0;

    irq_w1c_bank #(
        .W    (REG_W),
        .IMPL (CORE_IMPL)
    ) u_core_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (core_evt),
        .clr_i  (core_clr),
        .stat_o (core_stat)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_mask <= CORE_MASK_RST;
        end else if (bus_we && sel_core_mask) begin
            core_mask <= bus_wdata;
        end
    end

    logic core_pending;
    assign core_pending = |(core_stat & ~core_mask);

    // client status and mask
    logic [CLI_W-1:0] cli_latch;
    logic [CLI_W-1:0] cli_clr;
    logic [CLI_W-1:0] cli_view;
    logic [CLI_W-1:0] cli_mask;

    assign cli_clr = (bus_we && sel_cli_stat) ? bus_wdata[CLI_W-1:0] : '0;

    irq_w1c_bank #(
        .W    (CLI_W),
        .IMPL (CLI_IMPL)
    ) u_cli_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (cli_evt),
        .clr_i  (cli_clr),
        .stat_o (cli_latch)
    );

    assign cli_view = cli_latch | (core_pending ? LOCAL_ONEHOT : '0);

    irq_hiword_mask #(
        .W   (CLI_W),
        .RST (CLI_MASK_RST)
    ) u_cli_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (bus_we && sel_cli_mask),
        .wdata  (bus_wdata),
        .mask_o (cli_mask)
    );

    // interrupt groups
    logic [CLI_W-1:0] cli_live;
    assign cli_live = cli_view & ~cli_mask;

    localparam int GRP_N = 3;
    localparam int GRP_LO [GRP_N] = '{SUB_LO, INTX_LO, CLI_LO};
    localparam int GRP_HI [GRP_N] = '{SUB_HI, INTX_HI, CLI_HI};

    logic [GRP_N-1:0] grp_irq;

    for (genvar g = 0; g < GRP_N; g++) begin : g_grp
        logic [CLI_W-1:0] grp_sel;
        always_comb begin
            grp_sel = '0;
            for (int b = 0; b < CLI_W; b++) begin
                if (b >= GRP_LO[g] && b <= GRP_HI[g]) begin
                    grp_sel[b] = 1'b1;
                end
            end
        end
        assign grp_irq[g] = |(cli_live & grp_sel);
    end

    assign irq_sub  = grp_irq[0];
    assign irq_intx = grp_irq[1];
    assign irq_cli  = grp_irq[2];

    // legacy dispatcher on raw status
    irq_lowest_pick #(
        .N (INTX_N)
    ) u_pick (
        .req (cli_view[INTX_HI:INTX_LO]),
        .idx (intx_idx),
        .vld (intx_vld)
    );

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (sel_cli_stat) begin
            bus_rdata = {16'h0, cli_view};
        end else if (sel_cli_mask) begin
            bus_rdata = {16'h0, cli_mask};
        end else if (sel_core_stat) begin
            bus_rdata = core_stat;
        end else if (sel_core_mask) begin
            bus_rdata = core_mask;
        end else if (sel_intx) begin
            bus_rdata = {23'h0, intx_vld, 6'h0, intx_idx};
        end
    end

endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_we,
    input logic [2:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic [15:0] cli_evt,
    input logic [31:0] core_evt,
    input logic [15:0] cli_view,
    input logic [15:0] cli_mask,
    input logic [31:0] core_stat,
    input logic [31:0] core_mask,
    input logic        irq_cli,
    input logic [1:0]  intx_idx,
    input logic        intx_vld
);

    logic armed;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R2 / R4: an event leaves its bit set on the next cycle, clear or not
    p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ((cli_evt & 16'hFFEF) != 16'h0) |=>
        ((cli_view & $past(cli_evt & 16'hFFEF)) == $past(cli_evt & 16'hFFEF)));

    // R3: a clear with no coinciding event removes the bits
    p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (bus_we && bus_addr == 3'd2 && ((core_evt & bus_wdata) == 32'h0)) |=>
        ((core_stat & $past(bus_wdata)) == 32'h0));

    // R5: mask bits without an enable keep their value
    p_mask_keep_r5: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (bus_we && bus_addr == 3'd1) |=>
        (((cli_mask ^ $past(cli_mask)) & ~$past(bus_wdata[31:16])) == 16'h0));

    // R6: unimplemented core bits never set
    p_core_impl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((core_stat & 32'hFFF3_F000) == 32'h0));

    // R7: local summary tracks unmasked core errors
    p_local_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cli_view[4] == ((core_stat & ~core_mask) != 32'h0)));

    // R8: a quiet client line whenever nothing unmasked in 15..9
    p_cli_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((cli_view[15:9] & ~cli_mask[15:9]) == 7'h0) |-> !irq_cli);

    // R9: dispatcher points at a set bit with nothing set below it
    p_intx_lowest_r9: assert property (@(posedge clk) disable iff (!rst_n)
        intx_vld |-> (cli_view[5 + intx_idx] &&
                      ((cli_view[8:5] & ((4'b0001 << intx_idx) - 4'b0001)) == 4'h0)));

endmodule

bind irq_aggregator irq_aggregator_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .cli_evt   (cli_evt),
    .core_evt  (core_evt),
    .cli_view  (cli_view),
    .cli_mask  (cli_mask),
    .core_stat (core_stat),
    .core_mask (core_mask),
    .irq_cli   (irq_cli),
    .intx_idx  (intx_idx),
    .intx_vld  (intx_vld)
);

// File: tb/tb_irq_aggregator.sv
module tb_irq_aggregator;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] cli_evt = '0;
    logic [31:0] core_evt = '0;
    logic        irq_sub, irq_cli, irq_intx, intx_vld;
    logic [1:0]  intx_idx;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    irq_aggregator dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cli_evt   (cli_evt),
        .core_evt  (core_evt),
        .irq_sub   (irq_sub),
        .irq_cli   (irq_cli),
        .irq_intx  (irq_intx),
        .intx_idx  (intx_idx),
        .intx_vld  (intx_vld)
    );

    typedef struct packed {
        logic        we;
        logic [2:0]  waddr;
        logic [31:0] wdata;
        logic [15:0] cevt;
        logic [31:0] kevt;
        logic [2:0]  raddr;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 3'd0, 32'h0,         16'h0001, 32'h0,         3'd0, 32'h0000_0001, 8'd2},  // R2
        '{1'b1, 3'd1, 32'h0001_0000, 16'h0000, 32'h0,         3'd1, 32'h0000_FFFE, 8'd5},  // R5
        '{1'b1, 3'd1, 32'h0002_0001, 16'h0000, 32'h0,         3'd1, 32'h0000_FFFC, 8'd5},  // R5
        '{1'b0, 3'd0, 32'h0,         16'h0120, 32'h0,         3'd4, 32'h0000_0100, 8'd9},  // R9
        '{1'b1, 3'd0, 32'h0000_0020, 16'h0000, 32'h0,         3'd4, 32'h0000_0103, 8'd9},  // R9
        '{1'b0, 3'd0, 32'h0,         16'h0000, 32'h1,         3'd0, 32'h0000_0101, 8'd7},  // R7
        '{1'b1, 3'd3, 32'hFFFF_FFFE, 16'h0000, 32'h0,         3'd0, 32'h0000_0111, 8'd7},  // R7
        '{1'b0, 3'd0, 32'h0,         16'h0000, 32'hFFFF_FFFF, 3'd2, 32'h000C_0FFF, 8'd6},  // R6
        '{1'b1, 3'd2, 32'h0000_0FFF, 16'h0000, 32'h0,         3'd2, 32'h000C_0000, 8'd3},  // R3
        '{1'b1, 3'd0, 32'h0000_0010, 16'h0010, 32'h0,         3'd0, 32'h0000_0101, 8'd7},  // R7
        '{1'b1, 3'd5, 32'hFFFF_FFFF, 16'h0000, 32'h0,         3'd5, 32'h0000_0000, 8'd10}, // R10
        '{1'b1, 3'd0, 32'h0000_0001, 16'h0001, 32'h0,         3'd0, 32'h0000_0101, 8'd4},  // R4
        '{1'b1, 3'd0, 32'h0000_0101, 16'h0000, 32'h0,         3'd0, 32'h0000_0000, 8'd3}   // R3
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic we, input logic [2:0] wa, input logic [31:0] wd,
                        input logic [15:0] ce, input logic [31:0] ke);
        @(negedge clk);
        bus_we = we; bus_addr = wa; bus_wdata = wd; cli_evt = ce; core_evt = ke;
        @(posedge clk);
        #1;
        bus_we = 1'b0; bus_wdata = '0; cli_evt = '0; core_evt = '0;
    endtask

    task automatic rd(input logic [2:0] a, input string tag, input logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    initial begin
        #(4 * 100000);
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(3'd0, "R1 client status", 32'h0);
        rd(3'd1, "R1 client mask", 32'h0000_FFFF);
        rd(3'd2, "R1 core status", 32'h0);
        rd(3'd3, "R1 core mask", 32'hFFFF_FFFF);
        chk("R1 irq lines", {28'h0, irq_sub, irq_cli, irq_intx, intx_vld}, 32'h0);

        // vector walk
        for (int i = 0; i < NV; i++) begin
            step(TBL[i].we, TBL[i].waddr, TBL[i].wdata, TBL[i].cevt, TBL[i].kevt);
            rd(TBL[i].raddr, $sformatf("R%0d vector %0d", TBL[i].req, i), TBL[i].exp);
        end

        // R8 client line masked, then unmasked, then cleared (R3)
        step(1'b0, 3'd0, 32'h0, 16'h0200, 32'h0);
        chk("R8 irq_cli masked", {31'h0, irq_cli}, 32'h0);
        step(1'b1, 3'd1, 32'h0200_0000, 16'h0, 32'h0);
        chk("R8 irq_cli unmasked", {31'h0, irq_cli}, 32'h1);
        step(1'b1, 3'd0, 32'h0000_0200, 16'h0, 32'h0);
        chk("R3 irq_cli after clear", {31'h0, irq_cli}, 32'h0);

        // R9 dispatcher ignores mask; R8 intx line
        step(1'b0, 3'd0, 32'h0, 16'h0040, 32'h0);
        chk("R9 intx vld/idx", {29'h0, intx_vld, intx_idx}, 32'h5);
        chk("R8 irq_intx masked", {31'h0, irq_intx}, 32'h0);
        step(1'b1, 3'd1, 32'h0040_0000, 16'h0, 32'h0);
        chk("R8 irq_intx unmasked", {31'h0, irq_intx}, 32'h1);

        // R8 / R7 subsystem line through the core path
        step(1'b1, 3'd1, 32'h0010_0000, 16'h0, 32'h0);
        chk("R8 irq_sub idle", {31'h0, irq_sub}, 32'h0);
        step(1'b0, 3'd0, 32'h0, 16'h0, 32'h0000_0001);
        chk("R8 irq_sub via local", {31'h0, irq_sub}, 32'h1);
        step(1'b1, 3'd2, 32'h0000_0001, 16'h0, 32'h0);
        chk("R7 irq_sub after core clear", {31'h0, irq_sub}, 32'h0);
        rd(3'd0, "R7 local bit cleared", 32'h0000_0040);

        // R1 reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd(3'd1, "R1 mask after reset", 32'h0000_FFFF);
        rd(3'd0, "R1 status after reset", 32'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule